// File: doc/BRIEF.md
# Extended Hamming SECDED Codec for Byte Data

This block protects one 8-bit data byte with a 13-bit single-error-correcting, double-error-detecting code. The encoder path turns a byte into a codeword. That codeword has four check bits, the eight data bits, and one overall parity bit. The decoder path takes a codeword that may have been damaged in storage. It returns the repaired byte, the raw syndrome, and two flags: one for an error that was corrected and one for damage that could not be corrected. The two paths are independent of each other, so one word can be encoded while another is decoded in the same cycle.

Codeword positions are numbered 1 to 13, and position p is carried on bit p-1 of a codeword port. The decoder sorts every incoming word into one of five classes:
- CLS_CLEAN: no error.
- CLS_SINGLE: one bit flipped in positions 1 to 12.
- CLS_PARITY: only the parity bit in position 13 flipped.
- CLS_DOUBLE: two bits flipped.
- CLS_ALIAS: a syndrome that no single error can produce.

The class is re-evaluated from scratch for every word, so any class can follow any other. When the parameter `PIPE_OUT` is 1 (the default), all outputs are captured in one register stage. When it is 0, the outputs are combinational.

Top module: `secded13_codec`

## Requirements
- R1: The encoder places data bits enc_data_i[7] down to enc_data_i[0] into positions 3, 5, 6, 7, 9, 10, 11 and 12, in that order. Position p is carried on codeword bit p-1.
- R2: The encoder forms a 4-bit check value as the XOR of the position numbers of all data positions that hold a 1. Check bit 0 goes to position 1, bit 1 to position 2, bit 2 to position 4 and bit 3 to position 8.
- R3: The encoder sets position 13 so that the whole 13-bit codeword has an even number of ones.
- R4: dec_syndrome_o equals the XOR of the position numbers of all set bits in positions 1 to 12 of dec_word_i. It is 0 for every word the encoder can produce.
- R5: CLS_SINGLE applies when the syndrome is between 1 and 12 and the overall parity is odd. The bit at the syndrome position is inverted, dec_data_o carries the repaired byte, dec_corrected_o is 1 and dec_uncorrectable_o is 0.
- R6: CLS_PARITY applies when the syndrome is 0 and the overall parity is odd. dec_data_o is the unmodified data, dec_corrected_o is 1 and dec_uncorrectable_o is 0.
- R7: CLS_DOUBLE applies when the syndrome is nonzero and the overall parity is even. dec_uncorrectable_o is 1, dec_corrected_o is 0, and dec_data_o carries the received data bits, read per R1, without any change.
- R8: CLS_ALIAS applies when the syndrome is 13, 14 or 15, whatever the parity. It is handled like R7: uncorrectable flag set, corrected flag clear, data passed through.
- R9: CLS_CLEAN applies when the syndrome is 0 and the parity is even. Both flags are 0 and the data is passed through.
- R10: With PIPE_OUT=1, every output reflects the inputs that were present at the previous rising clock edge. A synchronous active-high rst clears all outputs, including both flags, to zero.
- R11: Data 8'b11001011 encodes to 13'b0110110010100 (bit 12 down to bit 0). With position 6 flipped, that word decodes to syndrome 6, data 8'b11001011 and the corrected flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst | input | 1 | Synchronous active-high reset |
| enc_data_i | input | 8 | Byte to encode |
| enc_word_o | output | 13 | Encoded codeword, bit p-1 holds position p |
| dec_word_i | input | 13 | Codeword to check and repair |
| dec_data_o | output | 8 | Repaired, or passed-through, data byte |
| dec_syndrome_o | output | 4 | Raw syndrome of dec_word_i |
| dec_corrected_o | output | 1 | An error was corrected (CLS_SINGLE or CLS_PARITY) |
| dec_uncorrectable_o | output | 1 | Damage could not be corrected (CLS_DOUBLE or CLS_ALIAS) |

## Verification
Encoding and decoding share the register stage and can both change in the same cycle. The bench therefore drives a fresh random byte into the encoder on every cycle. In that same cycle it feeds the decoder a different random byte, encoded by the bench and then damaged according to a randomly chosen pattern: no flips, one flip, two flips, or an arbitrary mask. Both result paths are compared, one cycle later, against bench models of the encoding rule and of the five decode classes. A crossed path or a stale register would show up as a mismatch on one of the two sides. Directed cases add the published example word, a lone parity-bit flip, and syndromes 13 to 15.

// File: rtl/secded13_pkg.sv
package secded13_pkg;

    localparam int DATA_W = 8;
    localparam int CODE_W = 13;
    localparam int SYN_W  = 4;
    localparam int NCHK   = SYN_W;

    typedef enum logic [2:0] {
        CLS_CLEAN  = 3'd0,
        CLS_SINGLE = 3'd1,
        CLS_PARITY = 3'd2,
        CLS_DOUBLE = 3'd3,
        CLS_ALIAS  = 3'd4
    } err_class_t;

    typedef struct packed {
        logic [CODE_W-1:0] enc_word;
        logic [DATA_W-1:0] dec_data;
        logic [SYN_W-1:0]  syndrome;
        logic              corrected;
        logic              uncorrectable;
    } codec_out_t;

    function automatic bit is_pow2(input int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    // position number (1-based) of the k-th data slot, k=0 holds the data MSB
    function automatic int data_pos(input int k);
        int cnt;
        cnt = 0;
        for (int p = 1; p < CODE_W; p++) begin
            if (!is_pow2(p)) begin
                if (cnt == k) return p;
                cnt++;
            end
        end
        return 0;
    endfunction

endpackage

// File: rtl/secded13_encoder.sv
module secded13_encoder
    import secded13_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] word_o
);

    logic [CODE_W-1:0] placed;
    logic [SYN_W-1:0]  chk;

    always_comb begin
        placed = '0;
        for (int k = 0; k < DATA_W; k++) begin
            placed[data_pos(k) - 1] = data_i[DATA_W - 1 - k];
        end
    end

    always_comb begin
        chk = '0;
        for (int p = 1; p < CODE_W; p++) begin
            if (placed[p - 1]) chk = chk ^ SYN_W'(p);
        end
    end

    always_comb begin
        word_o = placed;
        for (int j = 0; j < NCHK; j++) begin
            word_o[(1 << j) - 1] = chk[j];
        end
        word_o[CODE_W-1] = ^word_o[CODE_W-2:0];
    end

endmodule

// File: rtl/secded13_decoder.sv
module secded13_decoder
    import secded13_pkg::*;
(
    input  logic [CODE_W-1:0] word_i,
    output logic [DATA_W-1:0] data_o,
    output logic [SYN_W-1:0]  syndrome_o,
    output logic              corrected_o,
    output logic              uncorrectable_o
);

    logic [SYN_W-1:0]  syn;
    logic              par_odd;
    err_class_t        cls;
    logic [CODE_W-1:0] fixed;

    always_comb begin
        syn = '0;
        for (int p = 1; p < CODE_W; p++) begin
            if (word_i[p - 1]) syn = syn ^ SYN_W'(p);
        end
    end

    assign par_odd = ^word_i;

    always_comb begin
        if (syn == '0)
            cls = par_odd ? CLS_PARITY : CLS_CLEAN;
        else if (int'(syn) >= CODE_W)
            cls = CLS_ALIAS;
        else
            cls = par_odd ? CLS_SINGLE : CLS_DOUBLE;
    end

    always_comb begin
        fixed = word_i;
        for (int p = 1; p < CODE_W; p++) begin
            if (cls == CLS_SINGLE && syn == SYN_W'(p)) fixed[p - 1] = ~word_i[p - 1];
        end
    end

    always_comb begin
        for (int k = 0; k < DATA_W; k++) begin
            data_o[DATA_W - 1 - k] = fixed[data_pos(k) - 1];
        end
    end

    always_comb begin
        corrected_o     = 1'b0;
        uncorrectable_o = 1'b0;
        unique case (cls)
            CLS_CLEAN:  ;
            CLS_SINGLE: corrected_o     = 1'b1;
            CLS_PARITY: corrected_o     = 1'b1;
            CLS_DOUBLE: uncorrectable_o = 1'b1;
            CLS_ALIAS:  uncorrectable_o = 1'b1;
            default:    uncorrectable_o = 1'b1;
        endcase
    end

    assign syndrome_o = syn;

endmodule

// File: rtl/secded13_outreg.sv
module secded13_outreg
    import secded13_pkg::*;
#(
    parameter bit PIPE_OUT = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  codec_out_t d_i,
    output codec_out_t q_o
);

    generate
        if (PIPE_OUT) begin : g_reg
            codec_out_t q_r;
            always_ff @(posedge clk) begin
                if (rst) q_r <= '0;
                else     q_r <= d_i;
            end
            assign q_o = q_r;
        end else begin : g_wire
            assign q_o = d_i;
        end
    endgenerate

endmodule

// File: rtl/secded13_codec.sv
module secded13_codec
    import secded13_pkg::*;
#(
    parameter bit PIPE_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [CODE_W-1:0] enc_word_o,
    input  logic [CODE_W-1:0] dec_word_i,
    output logic [DATA_W-1:0] dec_data_o,
    output logic [SYN_W-1:0]  dec_syndrome_o,
    output logic              dec_corrected_o,
    output logic              dec_uncorrectable_o
);

    codec_out_t comb_out;
    codec_out_t reg_out;

    secded13_encoder u_enc (
        .data_i (enc_data_i),
        .word_o (comb_out.enc_word)
    );

    secded13_decoder u_dec (
        .word_i          (dec_word_i),
        .data_o          (comb_out.dec_data),
        .syndrome_o      (comb_out.syndrome),
        .corrected_o     (comb_out.corrected),
        .uncorrectable_o (comb_out.uncorrectable)
    );

    secded13_outreg #(.PIPE_OUT(PIPE_OUT)) u_reg (
        .clk (clk),
        .rst (rst),
        .d_i (comb_out),
        .q_o (reg_out)
    );

    assign enc_word_o          = reg_out.enc_word;
    assign dec_data_o          = reg_out.dec_data;
    assign dec_syndrome_o      = reg_out.syndrome;
    assign dec_corrected_o     = reg_out.corrected;
    assign dec_uncorrectable_o = reg_out.uncorrectable;

    // R5 R7
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(dec_corrected_o && dec_uncorrectable_o));

    // R3
    enc_even_chk: assert property (@(posedge clk) disable iff (rst)
        (^enc_word_o) == 1'b0);

    // R8
    alias_unc_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(dec_syndrome_o) >= CODE_W) |-> (dec_uncorrectable_o && !dec_corrected_o));

    // R9
    clean_syn_chk: assert property (@(posedge clk) disable iff (rst)
        (!dec_corrected_o && !dec_uncorrectable_o) |-> (dec_syndrome_o == '0));

    generate
        if (PIPE_OUT) begin : g_rst_chk
            // R10
            rst_clear_chk: assert property (@(posedge clk)
                rst |=> (!dec_corrected_o && !dec_uncorrectable_o && dec_data_o == '0));
        end
    endgenerate

endmodule

// File: tb/sim_secded13_codec.sv
module sim_secded13_codec;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  enc_data_i = '0;
    logic [12:0] enc_word_o;
    logic [12:0] dec_word_i = '0;
    logic [7:0]  dec_data_o;
    logic [3:0]  dec_syndrome_o;
    logic        dec_corrected_o;
    logic        dec_uncorrectable_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    secded13_codec u0 (
        .clk                 (clk),
        .rst                 (rst),
        .enc_data_i          (enc_data_i),
        .enc_word_o          (enc_word_o),
        .dec_word_i          (dec_word_i),
        .dec_data_o          (dec_data_o),
        .dec_syndrome_o      (dec_syndrome_o),
        .dec_corrected_o     (dec_corrected_o),
        .dec_uncorrectable_o (dec_uncorrectable_o)
    );

    localparam int DPOS [8] = '{3, 5, 6, 7, 9, 10, 11, 12};

    function automatic logic [12:0] ref_enc(input logic [7:0] d);
        logic [12:0] w;
        logic [3:0] c;
        w = '0;
        c = '0;
        for (int k = 0; k < 8; k++) begin
            w[DPOS[k]-1] = d[7-k];
            if (d[7-k]) c = c ^ 4'(DPOS[k]);
        end
        w[0] = c[0]; w[1] = c[1]; w[3] = c[2]; w[7] = c[3];
        w[12] = ^w[11:0];
        return w;
    endfunction

    function automatic logic [3:0] ref_syn(input logic [12:0] w);
        logic [3:0] s;
        s = '0;
        for (int p = 1; p <= 12; p++) if (w[p-1]) s = s ^ 4'(p);
        return s;
    endfunction

    function automatic logic [7:0] ref_extract(input logic [12:0] w);
        logic [7:0] d;
        for (int k = 0; k < 8; k++) d[7-k] = w[DPOS[k]-1];
        return d;
    endfunction

    logic [7:0]  exp_data;
    logic [3:0]  exp_syn;
    logic        exp_corr;
    logic        exp_unc;
    logic [12:0] exp_word;
    string       exp_req;

    task automatic ref_dec(input logic [12:0] w);
        logic [12:0] f;
        logic odd;
        f = w;
        odd = ^w;
        exp_syn = ref_syn(w);
        exp_corr = 1'b0;
        exp_unc = 1'b0;
        if (exp_syn == 0) begin
            exp_corr = odd;
            exp_req = odd ? "R6" : "R9";
        end else if (exp_syn >= 13) begin
            exp_unc = 1'b1;
            exp_req = "R8";
        end else if (odd) begin
            f[exp_syn-1] = ~f[exp_syn-1];
            exp_corr = 1'b1;
            exp_req = "R5";
        end else begin
            exp_unc = 1'b1;
            exp_req = "R7";
        end
        exp_data = ref_extract(f);
    endtask

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // drive at negedge, capture at posedge (R10 one-cycle latency), check at next negedge
    task automatic apply(input logic [7:0] ed, input logic [12:0] dw);
        @(negedge clk);
        enc_data_i = ed;
        dec_word_i = dw;
        exp_word = ref_enc(ed);
        ref_dec(dw);
        @(negedge clk);
        chk("R1 R2 R3 R10", "enc_word", 16'(enc_word_o), 16'(exp_word));
        chk({"R4 ", exp_req}, "syndrome", 16'(dec_syndrome_o), 16'(exp_syn));
        chk(exp_req, "data", 16'(dec_data_o), 16'(exp_data));
        chk(exp_req, "corrected", 16'(dec_corrected_o), 16'(exp_corr));
        chk(exp_req, "uncorrectable", 16'(dec_uncorrectable_o), 16'(exp_unc));
    endtask

    task automatic chk_reset;
        chk("R10", "rst data", 16'(dec_data_o), 16'h0);
        chk("R10", "rst word", 16'(enc_word_o), 16'h0);
        chk("R10", "rst corrected", 16'(dec_corrected_o), 16'h0);
        chk("R10", "rst uncorrectable", 16'(dec_uncorrectable_o), 16'h0);
        chk("R10", "rst syndrome", 16'(dec_syndrome_o), 16'h0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [12:0] w, mask;
        logic [7:0] d;
        int a, b, kind;
        void'($urandom(32'd4711));
        enc_data_i = 8'hA5;
        dec_word_i = 13'h1FFF;
        repeat (3) @(negedge clk);
        chk_reset();
        rst = 1'b0;

        // R11: published example, clean then position 6 flipped
        apply(8'b11001011, 13'b0110110010100);
        chk("R11", "example word", 16'(enc_word_o), 16'(13'b0110110010100));
        apply(8'b11001011, 13'b0110110010100 ^ 13'h0020);
        chk("R11", "example syndrome", 16'(dec_syndrome_o), 16'h6);
        chk("R11", "example data", 16'(dec_data_o), 16'(8'b11001011));
        chk("R11", "example corrected", 16'(dec_corrected_o), 16'h1);

        // R6: only parity bit flipped
        w = ref_enc(8'h3C) ^ 13'h1000;
        apply(8'h00, w);
        chk("R6", "parity-only data", 16'(dec_data_o), 16'h3C);

        // R8: syndromes 13..15 with odd parity and even parity
        for (int s = 13; s <= 15; s++) begin
            w = ref_enc(8'h5A);
            for (int p = 1; p <= 12; p++) begin
                if (s[0] && p == 1) w[0] = ~w[0];
                if (s[1] && p == 2) w[1] = ~w[1];
                if (s[2] && p == 4) w[3] = ~w[3];
                if (s[3] && p == 8) w[7] = ~w[7];
            end
            apply(8'hFF, w);
            chk("R8", "alias flag", 16'(dec_uncorrectable_o), 16'h1);
            apply(8'hFF, w ^ 13'h1000);
            chk("R8", "alias flag odd", 16'(dec_uncorrectable_o), 16'h1);
        end

        // R7: double error on data positions 3 and 5
        w = ref_enc(8'h81) ^ 13'h0014;
        apply(8'h7E, w);
        chk("R7", "double passthrough", 16'(dec_data_o), 16'(ref_extract(w)));

        // R5: every single position 1..12
        for (int p = 1; p <= 12; p++) begin
            d = 8'($urandom);
            apply(~d, ref_enc(d) ^ (13'h1 << (p - 1)));
            chk("R5", "single repair", 16'(dec_data_o), 16'(d));
        end

        // mixed random: encoder and decoder both active every cycle
        for (int i = 0; i < 2000; i++) begin
            d = 8'($urandom);
            w = ref_enc(8'($urandom));
            kind = $urandom_range(0, 3);
            a = $urandom_range(0, 12);
            b = (a + 1 + $urandom_range(0, 11)) % 13;
            case (kind)
                0: mask = '0;
                1: mask = 13'h1 << a;
                2: mask = (13'h1 << a) | (13'h1 << b);
                default: mask = 13'($urandom);
            endcase
            apply(d, w ^ mask);
        end

        // R10: mid-run synchronous reset
        @(negedge clk);
        enc_data_i = 8'hFF;
        dec_word_i = 13'h0003;
        rst = 1'b1;
        @(negedge clk);
        chk_reset();
        rst = 1'b0;
        apply(8'h01, ref_enc(8'h01));

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule